// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between a synchronous request port and an external asynchronous static RAM of 32768 bytes. Each accepted request becomes one memory access. For a write the block drives the active-low chip-enable and write-enable strobes and the data bus. For a read it drives chip-enable and output-enable, then samples the byte the memory returns. The data bus is bidirectional at the pad, so the block presents it as a separate output value, input value and driver enable.

The memory has no clock, so every timing rule becomes a whole number of system clocks. The block is given the clock period and the nanosecond figures of the memory's speed grade. It derives each phase length by rounding up, and every phase lasts at least one clock. An access always runs the same sequence: idle, then address setup with all strobes high, then the strobe phase, then recovery with all strobes high, then back to idle. A new request is taken only in idle. Output-enable stays high for the whole of a write, so the memory never drives the bus while the block does.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is held and on leaving it, all three strobes are high (1), the data driver is off, `rd_valid` is 0 and `req_ready` is 1.
- R2: The strobes take only three combinations. All high is idle. Chip-enable low with write-enable low and output-enable high is a write. Chip-enable low with output-enable low and write-enable high is a read. Write-enable or output-enable is never low while chip-enable is high.
- R3: `sram_addr` changes only while all strobes are high, and it holds the request address for the clock before the strobes fall.
- R4: In a write, chip-enable and write-enable fall together. They stay low for WR_STB = max(ceil(tWP/P), ceil(tAW/P), ceil(tDW/P)+1) clocks, which is 6 at the defaults.
- R5: The data driver turns on one clock after write-enable falls. It turns off one clock after write-enable rises. It holds the request's write byte the whole time it is on, and output-enable stays high throughout.
- R6: In a read, chip-enable and output-enable stay low for RD_STB = max(ceil(tAA/P), ceil(tOE/P)) clocks, which is 7 at the defaults. The byte on `sram_dq_in` at the last of those clocks is returned. It appears on `rd_data` with a one-clock `rd_valid` pulse in the clock after the strobes rise.
- R7: `req_ready` is 1 only in idle, and a request is accepted only when `req_valid` and `req_ready` are both 1. A held `req_valid` starts exactly one access per acceptance. From acceptance to the next ready, a write is busy 1+WR_STB+WR_REC clocks (8 at the defaults) and a read is busy 1+RD_STB+RD_REC clocks (11 at the defaults).
- R8: Each phase length is ceil(ns/P), raised to at least 1. Recovery tops up the cycle to ceil(tWC/P) for a write, or to ceil(tRC/P) for a read. Read recovery also lasts at least ceil(tHZ/P) clocks, which is 3 at the defaults.
- R9: A byte written to an address is read back unchanged. This holds for every address bit.
- R10: After a read, the data driver stays off until the memory's output turn-off time has passed, so the bus is never driven from both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this clock if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-clock pulse, `rd_data` holds the read byte |
| rd_data | output | 8 | Last read byte |
| sram_addr | output | 15 | Memory address bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Byte driven onto the data bus |
| sram_dq_in | input | 8 | Byte seen on the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable |

## Verification
A sequencer stuck in the wrong phase, or a phase timer loaded with the wrong count, changes the strobe widths and the busy time within the same access. So it shows at the ports no more than 11 clocks after acceptance, as a wrong low-time of write-enable or output-enable or a wrong count of busy clocks. A wrong driver or address register shows in the clock where it happens. The bench's memory model counts any address change while a strobe is low, any illegal strobe mix, and any clock where both sides drive the bus. A wrong capture point shows in the next `rd_valid` as a byte that differs from the scoreboard.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  // Clocks needed to cover ns nanoseconds, never less than one.
  function automatic int unsigned clocks_for(input int unsigned ns,
                                             input int unsigned period_ns);
    int unsigned q;
    q = (ns + period_ns - 1) / period_ns;
    if (q == 0) q = 1;
    return q;
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Clocks still missing to reach a total cycle length, at least one.
  function automatic int unsigned top_up(input int unsigned total,
                                         input int unsigned used);
    return (total > used) ? (total - used) : 1;
  endfunction

  // Counter width able to hold values 0 .. max_len-1.
  function automatic int unsigned count_width(input int unsigned max_len);
    int unsigned w;
    w = $clog2(max_len);
    return (w == 0) ? 1 : w;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == '0);

  // R8: a loaded phase runs down one clock at a time
  a_r8_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WR_STB    = 6,
  parameter int unsigned WR_REC    = 1,
  parameter int unsigned RD_STB    = 7,
  parameter int unsigned RD_REC    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_done,
  output logic             req_ready,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             capture,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drv_en
);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WSTB_LD  = CNT_W'(WR_STB - 1);
  localparam logic [CNT_W-1:0] WREC_LD  = CNT_W'(WR_REC - 1);
  localparam logic [CNT_W-1:0] RSTB_LD  = CNT_W'(RD_STB - 1);
  localparam logic [CNT_W-1:0] RREC_LD  = CNT_W'(RD_REC - 1);

  phase_e state_q, state_d;
  logic   op_wr_q;
  logic   ce_n_q, we_n_q, oe_n_q, drv_q;

  // Named events for the assertions and the datapath
  logic   in_idle, in_strobe, strobe_next, last_strobe_clk;

  assign in_idle         = (state_q == PH_IDLE);
  assign in_strobe       = (state_q == PH_STROBE);
  assign strobe_next     = (state_d == PH_STROBE);
  assign last_strobe_clk = in_strobe && timer_done;

  assign req_ready = in_idle;
  assign accept    = in_idle && req_valid;
  assign capture   = last_strobe_clk && !op_wr_q;

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (state_q)
      PH_IDLE: if (req_valid) begin
        state_d    = PH_SETUP;
        timer_load = 1'b1;
        timer_val  = SETUP_LD;
      end
      PH_SETUP: if (timer_done) begin
        state_d    = PH_STROBE;
        timer_load = 1'b1;
        timer_val  = op_wr_q ? WSTB_LD : RSTB_LD;
      end
      PH_STROBE: if (timer_done) begin
        state_d    = PH_RECOVER;
        timer_load = 1'b1;
        timer_val  = op_wr_q ? WREC_LD : RREC_LD;
      end
      PH_RECOVER: if (timer_done) begin
        state_d    = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      op_wr_q <= 1'b0;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_wr_q <= req_write;
      ce_n_q  <= !strobe_next;
      we_n_q  <= !(strobe_next && op_wr_q);
      oe_n_q  <= !(strobe_next && !op_wr_q);
      drv_q   <= in_strobe && op_wr_q;
    end
  end

  assign ce_n   = ce_n_q;
  assign we_n   = we_n_q;
  assign oe_n   = oe_n_q;
  assign drv_en = drv_q;

  // Checker state: length of the current low run of each strobe
  logic [15:0] we_run, oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= we_n_q ? 16'd0 : we_run + 16'd1;
      oe_run <= oe_n_q ? 16'd0 : oe_run + 16'd1;
    end
  end

  // R2: write or read strobes only under chip enable, never both
  a_r2_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> !ce_n_q);
  a_r2_oe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> (!ce_n_q && we_n_q));
  // R4: write strobe width
  a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (we_run == 16'(WR_STB)));
  // R5: output enable high while writing or driving
  a_r5_oe_high_writing: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_q || drv_q) |-> oe_n_q);
  // R5: driver turns on only a clock into the write strobe
  a_r5_drv_after_we: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> (!we_n_q && $past(!we_n_q)));
  // R5: driver released one clock after the strobe ends
  a_r5_drv_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> drv_q ##1 !drv_q);
  // R6: read strobe width
  a_r6_oe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n_q) |-> (oe_run == 16'(RD_STB)));
  // R7: ready only with every strobe high and the bus released
  a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n_q && we_n_q && oe_n_q && !drv_q));

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic              strobe_low,
  input  logic              drv_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= dq_in;
      rvalid_q <= capture;
    end
  end

  assign sram_addr = addr_q;
  assign dq_out    = wdata_q;
  assign rd_valid  = rvalid_q;
  assign rd_data   = rdata_q;

  // R3: address frozen while any strobe is low
  a_r3_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> $stable(addr_q));
  // R5: driven byte does not move while the driver is on
  a_r5_wdata_steady: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> $stable(wdata_q));
  // R6: read-valid is a single-clock pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_AS_NS       = 0,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 55,
  parameter int unsigned T_AW_NS       = 60,
  parameter int unsigned T_DW_NS       = 30,
  parameter int unsigned T_WR_NS       = 0,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_OE_NS       = 35,
  parameter int unsigned T_HZ_NS       = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int unsigned P         = CLK_PERIOD_NS;
  localparam int unsigned SETUP_CYC = clocks_for(T_AS_NS, P);
  // Driver starts one clock into the strobe, hence the +1 on data setup
  localparam int unsigned WR_STB    = max2(max2(clocks_for(T_WP_NS, P),
                                                clocks_for(T_AW_NS, P)),
                                           clocks_for(T_DW_NS, P) + 1);
  localparam int unsigned WR_REC    = max2(clocks_for(T_WR_NS, P),
                                           top_up(clocks_for(T_WC_NS, P),
                                                  SETUP_CYC + WR_STB));
  localparam int unsigned RD_STB    = max2(clocks_for(T_AA_NS, P),
                                           clocks_for(T_OE_NS, P));
  localparam int unsigned RD_REC    = max2(clocks_for(T_HZ_NS, P),
                                           top_up(clocks_for(T_RC_NS, P),
                                                  SETUP_CYC + RD_STB));
  localparam int unsigned MAX_PH    = max2(max2(max2(SETUP_CYC, WR_STB),
                                                max2(WR_REC, RD_STB)), RD_REC);
  localparam int unsigned CNT_W     = count_width(MAX_PH);

  logic             accept, capture, timer_load, timer_done;
  logic [CNT_W-1:0] timer_val;
  logic             ce_n, we_n, oe_n, drv_en, strobe_low;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (timer_done)
  );

  sram_seq_fsm #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .WR_STB    (WR_STB),
    .WR_REC    (WR_REC),
    .RD_STB    (RD_STB),
    .RD_REC    (RD_REC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .timer_done (timer_done),
    .req_ready  (req_ready),
    .accept     (accept),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .capture    (capture),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .drv_en     (drv_en)
  );

  assign strobe_low = !(ce_n && we_n && oe_n);

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .strobe_low (strobe_low),
    .drv_en     (drv_en),
    .dq_in      (sram_dq_in),
    .sram_addr  (sram_addr),
    .dq_out     (sram_dq_out),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign sram_ce_n  = ce_n;
  assign sram_we_n  = we_n;
  assign sram_oe_n  = oe_n;
  assign sram_dq_oe = drv_en;

endmodule

// File: tb/sram_strobe_ctrl_bench.sv
module sram_strobe_ctrl_bench;

  localparam int CLK_NS = 10;
  // Speed-grade figures handed to the design, restated here
  localparam int T_WC = 70, T_WP = 55, T_AW = 60, T_DW = 30;
  localparam int T_RC = 70, T_AA = 70, T_OE = 35, T_HZ = 25;

  function automatic int ck(input int ns);
    int c;
    c = ns / CLK_NS;
    if (c * CLK_NS < ns) c = c + 1;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  localparam int E_SETUP = 1;
  localparam int E_WSTB  = mx(mx(ck(T_WP), ck(T_AW)), ck(T_DW) + 1);
  localparam int E_WREC  = mx(1, ck(T_WC) - E_SETUP - E_WSTB);
  localparam int E_RSTB  = mx(ck(T_AA), ck(T_OE));
  localparam int E_RREC  = mx(ck(T_HZ), ck(T_RC) - E_SETUP - E_RSTB);
  localparam int HZ_CLK  = ck(T_HZ);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [14:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_out, sram_dq_in;

  always #(CLK_NS / 2) clk = ~clk;

  sram_strobe_ctrl #(
    .CLK_PERIOD_NS(CLK_NS),
    .T_WC_NS(T_WC), .T_WP_NS(T_WP), .T_AW_NS(T_AW), .T_DW_NS(T_DW),
    .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_OE_NS(T_OE), .T_HZ_NS(T_HZ)
  ) u_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out),
    .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
  );

  // ---------------- behavioural memory ----------------
  logic [7:0] model_mem [int unsigned];
  logic [7:0] mem_q;
  int         hold_cnt;
  logic       mem_reading, mem_drv;
  int         viol_cnt, clash_cnt;
  logic [14:0] prev_addr;
  logic        prev_low, prev_we;
  logic [7:0]  wr_lat;
  logic        wr_lat_v;

  function automatic logic [7:0] peek(input int unsigned k);
    if (model_mem.exists(k)) return model_mem[k];
    return 8'h00;
  endfunction

  assign mem_reading = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign mem_drv     = mem_reading || (hold_cnt != 0);
  assign sram_dq_in  = mem_drv ? mem_q : (sram_dq_oe ? sram_dq_out : 8'hFF);

  always @(posedge clk) begin
    mem_q <= peek(32'(sram_addr));
    if (mem_reading)        hold_cnt <= HZ_CLK;
    else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
  end

  always @(negedge clk) begin
    logic low_now;
    low_now = !sram_ce_n || !sram_we_n || !sram_oe_n;
    if (rst_n) begin
      if ((sram_addr != prev_addr) && (low_now || prev_low)) viol_cnt++;
      if (!sram_we_n && sram_ce_n) viol_cnt++;
      if (!sram_oe_n && (sram_ce_n || !sram_we_n)) viol_cnt++;
      if (sram_dq_oe && mem_drv) clash_cnt++;
      if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
        wr_lat   = sram_dq_out;
        wr_lat_v = 1'b1;
      end
      if (!prev_we && sram_we_n && wr_lat_v) begin
        model_mem[32'(sram_addr)] = wr_lat;
        wr_lat_v = 1'b0;
      end
    end
    prev_addr = sram_addr;
    prev_low  = low_now;
    prev_we   = sram_we_n;
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    hold_cnt = 0; viol_cnt = 0; clash_cnt = 0; wr_lat_v = 1'b0; wr_lat = '0;
    prev_addr = '0; prev_low = 1'b0; prev_we = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({sram_ce_n, sram_we_n, sram_oe_n} == 3'b111, "R1", "strobes in reset",
        int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
    chk(!sram_dq_oe && !rd_valid, "R1", "driver/valid in reset",
        int'({sram_dq_oe, rd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && sram_ce_n && sram_we_n && sram_oe_n, "R1", "ready after reset",
        int'({req_ready, sram_ce_n, sram_we_n, sram_oe_n}), 15);
  endtask

  task automatic t_idle_quiet(input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!(req_ready && sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe)) bad++;
      @(negedge clk);
    end
    // R2: idle encoding while no request
    chk(bad == 0, "R2", "idle strobes all high", bad, 0);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d);
    int n, we_lo, ce_lo, oe_lo, first_we, last_we, first_drv, last_drv, bad_d;
    logic [14:0] setup_addr;
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; we_lo = 0; ce_lo = 0; oe_lo = 0; bad_d = 0;
    first_we = -1; last_we = -1; first_drv = -1; last_drv = -1;
    setup_addr = sram_addr;
    while (!req_ready && n < 100) begin
      if (!sram_we_n) begin we_lo++; if (first_we < 0) first_we = n; last_we = n; end
      if (!sram_ce_n) ce_lo++;
      if (!sram_oe_n) oe_lo++;
      if (sram_dq_oe) begin
        if (first_drv < 0) first_drv = n;
        last_drv = n;
        if (sram_dq_out != d) bad_d++;
      end
      @(negedge clk); n++;
    end
    chk(setup_addr == a, "R3", "address before strobe", int'(setup_addr), int'(a));
    chk(we_lo == E_WSTB, "R4", "write strobe clocks", we_lo, E_WSTB);
    chk(ce_lo == we_lo, "R4", "CE low with WE", ce_lo, we_lo);
    chk(first_drv == first_we + 1, "R5", "driver on offset", first_drv, first_we + 1);
    chk(last_drv == last_we + 1, "R5", "driver off offset", last_drv, last_we + 1);
    chk(oe_lo == 0 && bad_d == 0, "R5", "OE high / data held", oe_lo + bad_d, 0);
    chk(n == E_SETUP + E_WSTB + E_WREC, "R7", "write busy clocks", n,
        E_SETUP + E_WSTB + E_WREC);
    chk(peek(32'(a)) == d, "R9", "memory holds written byte", int'(peek(32'(a))), int'(d));
  endtask

  task automatic t_read(input logic [14:0] a, input logic [7:0] exp_d);
    int n, oe_lo, ce_lo, last_oe, vcount, vidx;
    logic [7:0] got;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h00;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; oe_lo = 0; ce_lo = 0; last_oe = -1; vcount = 0; vidx = -1; got = '0;
    while (!req_ready && n < 100) begin
      if (!sram_oe_n) begin oe_lo++; last_oe = n; end
      if (!sram_ce_n) ce_lo++;
      if (rd_valid) begin vcount++; vidx = n; got = rd_data; end
      @(negedge clk); n++;
    end
    chk(oe_lo == E_RSTB && ce_lo == E_RSTB, "R6", "read strobe clocks", oe_lo, E_RSTB);
    chk(vcount == 1 && vidx == last_oe + 1, "R6", "rd_valid placement", vidx, last_oe + 1);
    chk(n == E_SETUP + E_RSTB + E_RREC, "R8", "read busy clocks", n,
        E_SETUP + E_RSTB + E_RREC);
    chk(got == exp_d, "R9", "read data", int'(got), int'(exp_d));
  endtask

  task automatic t_walk();
    for (int i = 0; i < 15; i++) t_write(15'(1 << i), 8'(i * 29 + 7));
    t_write(15'h0000, 8'h5A);
    t_write(15'h7FFF, 8'hC3);
    for (int i = 0; i < 15; i++) t_read(15'(1 << i), 8'(i * 29 + 7));
    t_read(15'h0000, 8'h5A);
    t_read(15'h7FFF, 8'hC3);
  endtask

  task automatic t_held_request();
    int acc, falls, loud;
    logic pw;
    acc = 0; falls = 0; loud = 0; pw = sram_we_n;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0155; req_wdata = 8'h3C;
    for (int i = 0; i < 30; i++) begin
      if (req_ready && req_valid) acc++;
      if (req_ready && !(sram_ce_n && sram_we_n && sram_oe_n)) loud++;
      if (pw && !sram_we_n) falls++;
      pw = sram_we_n;
      @(negedge clk);
    end
    req_valid = 1'b0;
    for (int i = 0; i < 15; i++) begin
      if (pw && !sram_we_n) falls++;
      pw = sram_we_n;
      @(negedge clk);
    end
    // R7: one access per acceptance, ready only when quiet
    chk(acc >= 2 && falls == acc, "R7", "strobes per acceptance", falls, acc);
    chk(loud == 0, "R7", "ready with strobe low", loud, 0);
  endtask

  task automatic t_turnaround();
    t_write(15'h2AAA, 8'h96);
    t_read(15'h2AAA, 8'h96);
    t_write(15'h1555, 8'h69);
    t_read(15'h1555, 8'h69);
    t_read(15'h2AAA, 8'h96);
    // R10: no clock with both sides driving
    chk(clash_cnt == 0, "R10", "bus contention clocks", clash_cnt, 0);
  endtask

  task automatic t_protocol_clean();
    // R2 and R3: memory model saw no illegal strobe mix or address move
    chk(viol_cnt == 0, "R3", "protocol violations", viol_cnt, 0);
    chk(E_WSTB == 6 && E_RSTB == 7 && E_RREC == 3, "R8", "derived phase counts",
        E_WSTB * 100 + E_RSTB * 10 + E_RREC, 673);
  endtask

  initial begin
    t_reset();
    t_idle_quiet(8);
    t_write(15'h1234, 8'hA5);
    t_read(15'h1234, 8'hA5);
    t_walk();
    t_held_request();
    t_turnaround();
    t_idle_quiet(6);
    t_protocol_clean();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule